// File: doc/BRIEF.md
# Page Prefetch Buffer for Byte-Wide Instruction Fetch

This block sits between a fetch unit that asks for one instruction byte at a time and a controller for slow external byte-wide memory. It holds one 256-byte page locally, along with the page number of that page and a count of how many of its bytes have already arrived. A request whose page matches the held page, and whose byte has already been loaded, is answered from the local buffer without touching external memory.

A request for any other page replaces the held page. The block then streams the new page in, one byte per memory transaction, starting at the first byte of the page. The requester gets its byte in the same cycle that byte arrives from memory, and the rest of the page keeps loading in the background. A request to a byte of the loading page that has not arrived yet waits for it. A request to a third page cancels the load at the next transaction boundary and starts the new page.

Top module: `pf_prefetch`

## Requirements
- R1: After reset, `resp_valid` and `mem_req` are low and no page is held, so the first request always fetches from memory.
- R2: A request address splits into a page offset (low 8 bits) and a page number (the upper bits). A request with the same offset but a different page number is a miss.
- R3: A request to a byte that is already loaded in the held page is answered with `resp_valid` in the next cycle and starts no memory transaction.
- R4: On a miss, the block drives `mem_req` with `mem_addr` = {page number, offset}. The offset starts at 0 and goes up by one after each cycle in which `mem_req` and `mem_ack` are both high. After offset 255 is accepted, `mem_req` drops.
- R5: The requested byte is answered in the cycle right after the memory transaction that delivers it. The only exception is when a response was already given in that cycle; then the answer comes one cycle later.
- R6: A request to the page being loaded, at an offset not yet loaded, waits and does not restart the load.
- R7: A miss during a load cancels that load at the end of the transaction in flight. `mem_addr` never changes while `mem_req` is high and `mem_ack` is low.
- R8: `resp_valid` is high for exactly one cycle per answer. The requester holds `req_valid` and `req_addr` until it sees `resp_valid`. A request still present in the cycle after an answer is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 18 | Byte address of the requested byte |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_data | output | 8 | Requested byte, valid with `resp_valid` |
| mem_req | output | 1 | Memory transaction requested |
| mem_addr | output | 18 | Byte address of the current transaction |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 8 | Byte returned, valid with `mem_ack` |

## Verification
The hardest case to reach is a request for a third page while a load is still running. It must wait for the transaction in flight and then restart at offset 0 of the new page. The bench reaches it by asking for offset 0 of a fresh page, which returns after the first transaction. It then asks at once for a different page, so the second transaction of the old load is still running. The number of memory transactions counted before each answer shows whether the cancel, the restart from offset 0 and the early answer all happened on the right transaction. A later request back to the cancelled page proves that page was dropped.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef logic [7:0] pf_byte_t;
endpackage

// File: rtl/pf_page_ram.sv
module pf_page_ram
    import pf_pkg::*;
#(
    parameter int OFFS_W = 8,
    localparam int DEPTH = 1 << OFFS_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [OFFS_W-1:0] waddr,
    input  pf_byte_t          wdata,
    input  logic [OFFS_W-1:0] raddr,
    output pf_byte_t          rdata
);
    pf_byte_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/pf_fill_ctrl.sv
module pf_fill_ctrl #(
    parameter int ADDR_W = 18,
    parameter int OFFS_W = 8,
    localparam int TAG_W = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [OFFS_W-1:0] req_off,
    input  logic              mem_ack,
    output logic              tag_match,
    output logic              byte_ready,
    output logic              byte_landing,
    output logic              fill_we,
    output logic [OFFS_W-1:0] fill_off,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [OFFS_W:0]   fill;
    } ctl_t;

    ctl_t st_d, st_q;
    logic filling, landing, switch_pg;

    always_comb begin
        st_d       = st_q;
        filling    = st_q.valid && !st_q.fill[OFFS_W];
        landing    = filling && mem_ack;
        tag_match  = st_q.valid && (req_tag == st_q.tag);
        byte_ready = tag_match && ({1'b0, req_off} < st_q.fill);
        byte_landing = tag_match && landing && (st_q.fill[OFFS_W-1:0] == req_off);
        switch_pg  = req_valid && !tag_match && (!filling || mem_ack);
        if (landing) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        if (switch_pg) begin
            st_d.valid = 1'b1;
            st_d.tag   = req_tag;
            st_d.fill  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_we  = landing;
    assign fill_off = st_q.fill[OFFS_W-1:0];
    assign mem_req  = filling;
    assign mem_addr = {st_q.tag, st_q.fill[OFFS_W-1:0]};
endmodule

// File: rtl/pf_prefetch.sv
module pf_prefetch
    import pf_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFFS_W = 8,
    localparam int TAG_W = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [7:0]        resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);
    typedef struct packed {
        logic     valid;
        pf_byte_t data;
    } resp_t;

    resp_t resp_d, resp_q;
    logic [TAG_W-1:0]  req_tag;
    logic [OFFS_W-1:0] req_off;
    logic tag_match, byte_ready, byte_landing, fill_we;
    logic [OFFS_W-1:0] fill_off;
    pf_byte_t ram_rdata;

    assign req_tag = req_addr[ADDR_W-1:OFFS_W];
    assign req_off = req_addr[OFFS_W-1:0];

    pf_fill_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_tag      (req_tag),
        .req_off      (req_off),
        .mem_ack      (mem_ack),
        .tag_match    (tag_match),
        .byte_ready   (byte_ready),
        .byte_landing (byte_landing),
        .fill_we      (fill_we),
        .fill_off     (fill_off),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr)
    );

    pf_page_ram #(.OFFS_W(OFFS_W)) u_ram (
        .clk   (clk),
        .we    (fill_we),
        .waddr (fill_off),
        .wdata (mem_rdata),
        .raddr (req_off),
        .rdata (ram_rdata)
    );

    always_comb begin
        resp_d       = resp_q;
        resp_d.valid = req_valid && !resp_q.valid && (byte_ready || byte_landing);
        if (resp_d.valid) begin
            resp_d.data = byte_ready ? ram_rdata : mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_data  = resp_q.data;

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3
    answer_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(req_valid));

    // R4
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFFS_W-1:0] != '1) &&
         !(req_valid && (req_tag != mem_addr[ADDR_W-1:OFFS_W])))
        |=> (mem_req && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

    // R4
    fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFFS_W-1:0] == '1) &&
         !(req_valid && (req_tag != mem_addr[ADDR_W-1:OFFS_W])))
        |=> !mem_req);
endmodule

// File: tb/tb_pf_prefetch.sv
module tb_pf_prefetch;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        resp_valid;
    logic [7:0]  resp_data;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int acks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pf_prefetch dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] fb(input logic [17:0] a);
        fb = (a[7:0] * 8'd7) + (a[15:8] * 8'd13) + ({6'd0, a[17:16]} * 8'd53);
    endfunction

    // memory model: ack after LAT cycles of a held request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0; cnt = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0; cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt >= LAT) begin
                    mem_ack = 1'b1;
                    mem_rdata = fb(mem_addr);
                end
            end else begin
                cnt = 0;
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) acks <= acks + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [17:0] a, output int lat, output int ack_at,
                         output logic [7:0] got);
        req_addr = a; req_valid = 1'b1; lat = 0;
        do begin
            @(negedge clk); lat++;
        end while (!resp_valid && lat < 5000);
        ack_at = acks; got = resp_data;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (mem_req) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // {idle, kind, addr}: kind 0 fast hit, 1 fresh miss, 2 stall on loading page
    localparam logic [20:0] VEC [11] = '{
        {1'b1, 2'd1, 18'h01234},
        {1'b0, 2'd0, 18'h01200},
        {1'b0, 2'd2, 18'h01290},
        {1'b1, 2'd0, 18'h012FF},
        {1'b0, 2'd0, 18'h01210},
        {1'b1, 2'd1, 18'h2AB00},
        {1'b0, 2'd2, 18'h2AB01},
        {1'b0, 2'd2, 18'h2ABFF},
        {1'b0, 2'd0, 18'h2AB80},
        {1'b1, 2'd1, 18'h3FFFF},
        {1'b1, 2'd1, 18'h00000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, ack_at, a0, page_start;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1 idle after release", int'(mem_req), 0);
        page_start = 0;

        for (int i = 0; i < 11; i++) begin
            logic [17:0] a;
            logic [1:0]  kind;
            a = VEC[i][17:0];
            kind = VEC[i][19:18];
            if (VEC[i][20]) wait_idle();
            a0 = acks;
            if (kind == 2'd1) page_start = a0;
            issue(a, lat, ack_at, got);
            chk(got == fb(a), "R3/R5 data", int'(got), int'(fb(a)));
            if (kind == 2'd0)
                chk(lat == 1, "R3 hit latency", lat, 1);
            else if (kind == 2'd1)
                // R1 R2 R4 R5: fill from offset 0, answer right after byte lands
                chk(ack_at - a0 == int'(a[7:0]) + 1, "R4/R5 miss transactions", ack_at - a0, int'(a[7:0]) + 1);
            else
                // R6: waits on the loading page without restart
                chk(ack_at - page_start == int'(a[7:0]) + 1, "R6 stall transactions", ack_at - page_start, int'(a[7:0]) + 1);
        end

        // R2: same offset, new page must miss
        wait_idle();
        a0 = acks;
        issue(18'h10000, lat, ack_at, got);
        chk(lat > 1 && ack_at - a0 == 1, "R2 same offset other page misses", ack_at - a0, 1);

        // R3: hit on a complete page makes no memory traffic
        wait_idle();
        a0 = acks;
        issue(18'h10042, lat, ack_at, got);
        chk(got == fb(18'h10042), "R3 idle hit data", int'(got), int'(fb(18'h10042)));
        @(negedge clk);
        chk(acks == a0 && !mem_req, "R3 no transaction on hit", acks - a0, 0);

        // R7: abort a running load
        wait_idle();
        issue(18'h05000, lat, ack_at, got);
        a0 = acks;
        issue(18'h07005, lat, ack_at, got);
        chk(got == fb(18'h07005), "R7 data after abort", int'(got), int'(fb(18'h07005)));
        chk(ack_at - a0 >= 6 && ack_at - a0 <= 7, "R7 restart at offset 0", ack_at - a0, 6);
        a0 = acks;
        issue(18'h05064, lat, ack_at, got);
        chk(got == fb(18'h05064), "R7 cancelled page data", int'(got), int'(fb(18'h05064)));
        chk(ack_at - a0 >= 101 && ack_at - a0 <= 102, "R7 cancelled page refetched", ack_at - a0, 101);

        // R8: request held after the answer is ignored for one cycle
        wait_idle();
        req_addr = 18'h05010; req_valid = 1'b1;
        @(negedge clk);
        chk(resp_valid == 1'b1, "R8 first answer", int'(resp_valid), 1);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8 held request ignored", int'(resp_valid), 0);
        @(negedge clk);
        chk(resp_valid == 1'b1 && resp_data == fb(18'h05010), "R8 answered again", int'(resp_data), int'(fb(18'h05010)));
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule